// File: doc/BRIEF.md
# Sample Input Selector and Formatter

This block sits at the head of a sample processing chain. It has four parallel 17-bit input lanes, each with its own sample-valid strobe. It also has a 16-bit test word with its own strobe, which the processor loads. Static configuration picks one of these sources. The block converts the chosen word into a 16-bit two's-complement sample and presents it, with an aligned enable, one clock later.

Two pacing modes are supported:
- **Gated mode:** a sample leaves the block only on clocks where the chosen strobe is high. The output enable copies that strobe.
- **Interpolated mode:** the output enable is high on every clock, and clocks without a strobe carry a zero sample. This stuffs zeros into the stream up to the clock rate.

Input words can be fixed point or a mantissa/exponent floating-point word, in two's complement or offset binary. After reset the block ignores its inputs until the first sync pulse arrives, on either the shared sync line or any per-lane sync line.

Top module: `smp_ingress`

## Requirements
- R1: With `cfg_use_test`=0 the word and strobe come from lane `cfg_src_sel`, where lane i occupies `bus_data[17*i+16:17*i]` and `bus_en[i]`. With `cfg_use_test`=1 they come from `test_word` and `test_en`, and the test word is taken as the 17-bit word `{test_word,1'b0}`.
- R2: After reset, `out_en` and `out_data` stay 0 whatever the inputs, until a sync pulse (`sync_all` or any bit of `sync_lane`) is sampled. Inputs sampled on that same edge are still ignored. From the next edge on the block is live, and it stays live until the next reset.
- R3: In gated mode (`cfg_interp`=0) a live block sets `out_en` to the chosen strobe. It outputs the converted sample when the strobe is 1 and 0 when it is 0.
- R4: In interpolated mode (`cfg_interp`=1) a live block holds `out_en` at 1 on every clock and outputs 0 on clocks whose chosen strobe is 0.
- R5: Output data and enable are registered together, one clock after the inputs are sampled.
- R6: With `cfg_offset_bin`=1, bit 16 of the chosen word is inverted before conversion. This turns offset binary into two's complement for every layout.
- R7: With `cfg_float`=0, `cfg_split[0]`=0 selects a 16-bit value in word bits 16:1. `cfg_split[0]`=1 selects a 15-bit value in bits 16:2, output as `{bits16:2,1'b0}`.
- R8: With `cfg_float`=1, the mantissa occupies the top M word bits and the exponent the low E bits. `cfg_split` 0..4 select M/E = 11/3, 12/3, 13/3, 14/2, 14/3, and 5..7 also select 14/3. The output is the sign-extended mantissa shifted left by the exponent.
- R9: A floating-point result keeps only the low 16 bits of the shifted value, so results past the 16-bit range wrap.
- R10: While `rst` is high at a clock edge, the outputs become 0 and the hold-off of R2 is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 68 | Four 17-bit input lanes, lane i at bits 17*i+16:17*i |
| bus_en | input | 4 | Per-lane sample strobe, active high |
| test_word | input | 16 | Processor-loaded test sample |
| test_en | input | 1 | Strobe for the test sample |
| cfg_use_test | input | 1 | 1 = test word, 0 = external lane |
| cfg_src_sel | input | 2 | External lane index |
| cfg_interp | input | 1 | 1 = interpolated, 0 = gated |
| cfg_offset_bin | input | 1 | 1 = offset-binary input |
| cfg_float | input | 1 | 1 = floating-point input |
| cfg_split | input | 3 | Field layout code (R7, R8) |
| sync_all | input | 1 | Shared sync pulse releasing the hold-off |
| sync_lane | input | 4 | Per-lane sync pulses, any one releases the hold-off |
| out_data | output | 16 | Two's-complement sample |
| out_en | output | 1 | Output sample enable |

## Verification
The assertions check three things on every clock:
- the hold-off keeps both outputs at zero until a sync has been seen;
- a live block in interpolated mode raises the enable on every clock;
- in gated mode the output enable follows the chosen strobe, and a clock without a strobe yields a zero sample.

Only the bench's directed scenarios can show that the converted numbers are correct. These cover:
- each fixed and floating layout;
- offset-binary inversion;
- wrap past 16 bits;
- lane routing versus the test word;
- that the sync edge itself discards its sample.

// File: rtl/smp_ingress_pkg.sv
package smp_ingress_pkg;

    localparam int WORD_W = 17;
    localparam int OUT_W  = 16;
    localparam int TEST_W = 16;
    localparam int SPLIT_W = 3;

    typedef enum logic [2:0] {
        LAY_FX16,
        LAY_FX15,
        LAY_F11E3,
        LAY_F12E3,
        LAY_F13E3,
        LAY_F14E2,
        LAY_F14E3
    } layout_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] word;
    } smp_t;

    function automatic layout_e decode_layout(logic is_float, logic [SPLIT_W-1:0] split);
        layout_e lay;
        if (!is_float) begin
            lay = split[0] ? LAY_FX15 : LAY_FX16;
        end else begin
            case (split)
                3'd0:    lay = LAY_F11E3;
                3'd1:    lay = LAY_F12E3;
                3'd2:    lay = LAY_F13E3;
                3'd3:    lay = LAY_F14E2;
                default: lay = LAY_F14E3;
            endcase
        end
        return lay;
    endfunction

    // Number of low bits to drop to leave the mantissa right-aligned.
    function automatic logic [4:0] mant_drop(layout_e lay);
        logic [4:0] d;
        case (lay)
            LAY_F11E3: d = 5'(WORD_W - 11);
            LAY_F12E3: d = 5'(WORD_W - 12);
            LAY_F13E3: d = 5'(WORD_W - 13);
            default:   d = 5'(WORD_W - 14);
        endcase
        return d;
    endfunction

    function automatic logic [OUT_W-1:0] float_to_fixed(logic [WORD_W-1:0] w, layout_e lay);
        logic [WORD_W-1:0] mant;
        logic [2:0]        ex;
        logic [WORD_W+7:0] wide;
        mant = WORD_W'($signed(w) >>> mant_drop(lay));
        ex   = (lay == LAY_F14E2) ? {1'b0, w[1:0]} : w[2:0];
        wide = {{8{mant[WORD_W-1]}}, mant} << ex;
        return wide[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/smp_src_mux.sv
module smp_src_mux
    import smp_ingress_pkg::*;
#(
    parameter int NUM_BUS = 4,
    localparam int SEL_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic [NUM_BUS*WORD_W-1:0] bus_data,
    input  logic [NUM_BUS-1:0]        bus_en,
    input  logic [TEST_W-1:0]         test_word,
    input  logic                      test_en,
    input  logic                      use_test,
    input  logic [SEL_W-1:0]          src_sel,
    output smp_t                      pick
);

    smp_t lanes [NUM_BUS];

    for (genvar i = 0; i < NUM_BUS; i++) begin : g_lane
        assign lanes[i].word = bus_data[i*WORD_W +: WORD_W];
        assign lanes[i].en   = bus_en[i];
    end

    always_comb begin
        if (use_test) begin
            pick.word = {test_word, {(WORD_W-TEST_W){1'b0}}};
            pick.en   = test_en;
        end else if (32'(src_sel) < NUM_BUS) begin
            pick = lanes[src_sel];
        end else begin
            pick = '0;
        end
    end

endmodule

// File: rtl/smp_holdoff.sv
module smp_holdoff #(
    parameter int NUM_SYNC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_all,
    input  logic [NUM_SYNC-1:0] sync_lane,
    output logic                live
);

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0;
        end else if (sync_all || (|sync_lane)) begin
            live <= 1'b1;
        end
    end

endmodule

// File: rtl/smp_fmt_conv.sv
module smp_fmt_conv
    import smp_ingress_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              offset_bin,
    input  layout_e           lay,
    output logic [OUT_W-1:0]  value
);

    logic [WORD_W-1:0] tc_word;

    assign tc_word = {word_in[WORD_W-1] ^ offset_bin, word_in[WORD_W-2:0]};

    always_comb begin
        case (lay)
            LAY_FX16: value = tc_word[WORD_W-1 -: OUT_W];
            LAY_FX15: value = {tc_word[WORD_W-1 -: OUT_W-1], 1'b0};
            default:  value = float_to_fixed(tc_word, lay);
        endcase
    end

endmodule

// File: rtl/smp_ingress.sv
module smp_ingress
    import smp_ingress_pkg::*;
#(
    parameter int NUM_BUS = 4,
    localparam int SEL_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_BUS*WORD_W-1:0] bus_data,
    input  logic [NUM_BUS-1:0]        bus_en,
    input  logic [TEST_W-1:0]         test_word,
    input  logic                      test_en,
    input  logic                      cfg_use_test,
    input  logic [SEL_W-1:0]          cfg_src_sel,
    input  logic                      cfg_interp,
    input  logic                      cfg_offset_bin,
    input  logic                      cfg_float,
    input  logic [SPLIT_W-1:0]        cfg_split,
    input  logic                      sync_all,
    input  logic [NUM_BUS-1:0]        sync_lane,
    output logic [OUT_W-1:0]          out_data,
    output logic                      out_en
);

    smp_t             pick;
    logic             live;
    logic [OUT_W-1:0] conv;
    layout_e          lay;

    assign lay = decode_layout(cfg_float, cfg_split);

    smp_src_mux #(.NUM_BUS(NUM_BUS)) mux_i (
        .bus_data (bus_data),
        .bus_en   (bus_en),
        .test_word(test_word),
        .test_en  (test_en),
        .use_test (cfg_use_test),
        .src_sel  (cfg_src_sel),
        .pick     (pick)
    );

    smp_holdoff #(.NUM_SYNC(NUM_BUS)) hold_i (
        .clk      (clk),
        .rst      (rst),
        .sync_all (sync_all),
        .sync_lane(sync_lane),
        .live     (live)
    );

    smp_fmt_conv conv_i (
        .word_in   (pick.word),
        .offset_bin(cfg_offset_bin),
        .lay       (lay),
        .value     (conv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_en   <= 1'b0;
        end else begin
            out_en   <= live && (cfg_interp || pick.en);
            out_data <= (live && pick.en) ? conv : '0;
        end
    end

endmodule

// File: rtl/smp_ingress_chk.sv
module smp_ingress_chk
    import smp_ingress_pkg::*;
#(
    parameter int NUM_BUS = 4,
    localparam int SEL_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_BUS-1:0]   bus_en,
    input logic                 test_en,
    input logic                 cfg_use_test,
    input logic [SEL_W-1:0]     cfg_src_sel,
    input logic                 cfg_interp,
    input logic                 sync_all,
    input logic [NUM_BUS-1:0]   sync_lane,
    input logic [OUT_W-1:0]     out_data,
    input logic                 out_en
);

    logic seen_sync;
    logic strobe;

    always_ff @(posedge clk) begin
        if (rst)                              seen_sync <= 1'b0;
        else if (sync_all || (|sync_lane))    seen_sync <= 1'b1;
    end

    assign strobe = cfg_use_test ? test_en : bus_en[cfg_src_sel];

    // R2
    a_r2_holdoff_quiet: assert property (@(posedge clk) disable iff (rst)
        !seen_sync |=> (!out_en && out_data == '0));

    // R4
    a_r4_interp_every_clock: assert property (@(posedge clk) disable iff (rst)
        (seen_sync && cfg_interp) |=> out_en);

    // R3
    a_r3_gated_follow_high: assert property (@(posedge clk) disable iff (rst)
        (seen_sync && !cfg_interp && strobe) |=> out_en);

    // R3
    a_r3_gated_follow_low: assert property (@(posedge clk) disable iff (rst)
        (seen_sync && !cfg_interp && !strobe) |=> !out_en);

    // R3, R4
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> out_data == '0);

endmodule

bind smp_ingress smp_ingress_chk #(.NUM_BUS(NUM_BUS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .test_en     (test_en),
    .cfg_use_test(cfg_use_test),
    .cfg_src_sel (cfg_src_sel),
    .cfg_interp  (cfg_interp),
    .sync_all    (sync_all),
    .sync_lane   (sync_lane),
    .out_data    (out_data),
    .out_en      (out_en)
);

// File: tb/smp_ingress_tb_top.sv
module smp_ingress_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [67:0] bus_data;
    logic [3:0]  bus_en;
    logic [15:0] test_word;
    logic        test_en;
    logic        cfg_use_test;
    logic [1:0]  cfg_src_sel;
    logic        cfg_interp;
    logic        cfg_offset_bin;
    logic        cfg_float;
    logic [2:0]  cfg_split;
    logic        sync_all;
    logic [3:0]  sync_lane;
    logic [15:0] out_data;
    logic        out_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    smp_ingress dut_i (
        .clk(clk), .rst(rst), .bus_data(bus_data), .bus_en(bus_en),
        .test_word(test_word), .test_en(test_en), .cfg_use_test(cfg_use_test),
        .cfg_src_sel(cfg_src_sel), .cfg_interp(cfg_interp),
        .cfg_offset_bin(cfg_offset_bin), .cfg_float(cfg_float),
        .cfg_split(cfg_split), .sync_all(sync_all), .sync_lane(sync_lane),
        .out_data(out_data), .out_en(out_en)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] exp_d, logic exp_e);
        n_chk++;
        if (out_data !== exp_d || out_en !== exp_e) begin
            n_fail++;
            $display("FAIL %s: data=%h en=%b expected data=%h en=%b",
                     req, out_data, out_en, exp_d, exp_e);
        end
    endtask

    task automatic set_lane(int i, logic [16:0] w, logic e);
        bus_data[i*17 +: 17] = w;
        bus_en[i]            = e;
    endtask

    task automatic idle();
        bus_data = '0; bus_en = '0; test_word = '0; test_en = 1'b0;
        sync_all = 1'b0; sync_lane = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        cfg_use_test = 1'b0; cfg_src_sel = '0; cfg_interp = 1'b0;
        cfg_offset_bin = 1'b0; cfg_float = 1'b0; cfg_split = '0;
        step(); step();
        chk("R10", 16'h0000, 1'b0);
        rst = 1'b0;
    endtask

    task automatic release_sync();
        sync_all = 1'b1;
        step();
        sync_all = 1'b0;
    endtask

    task automatic t_holdoff();
        do_reset();
        set_lane(0, {16'h1234, 1'b0}, 1'b1);
        step();
        chk("R2", 16'h0000, 1'b0);
        cfg_interp = 1'b1;
        step();
        chk("R2", 16'h0000, 1'b0);
        cfg_interp = 1'b0;
        sync_lane[2] = 1'b1;
        step();
        chk("R2", 16'h0000, 1'b0);
        sync_lane = '0;
        step();
        chk("R2", 16'h1234, 1'b1);
        set_lane(0, {16'h0042, 1'b0}, 1'b1);
        step(); step();
        chk("R2", 16'h0042, 1'b1);
    endtask

    task automatic t_source();
        do_reset();
        release_sync();
        for (int i = 0; i < 4; i++) set_lane(i, {16'(16'hA000 + i), 1'b0}, 1'b0);
        for (int i = 0; i < 4; i++) begin
            cfg_src_sel = 2'(i);
            bus_en = 4'(1 << i);
            step();
            chk("R1", 16'(16'hA000 + i), 1'b1);
        end
        cfg_src_sel = 2'd1;
        bus_en = 4'b1101;
        step();
        chk("R1", 16'h0000, 1'b0);
        cfg_use_test = 1'b1;
        test_word = 16'h5A5A; test_en = 1'b1;
        bus_en = 4'b1111;
        step();
        chk("R1", 16'h5A5A, 1'b1);
        test_en = 1'b0;
        step();
        chk("R1", 16'h0000, 1'b0);
        cfg_use_test = 1'b0;
    endtask

    task automatic t_gated();
        do_reset();
        release_sync();
        set_lane(0, {16'h0101, 1'b0}, 1'b1);
        step();
        chk("R3", 16'h0101, 1'b1);
        set_lane(0, {16'h0202, 1'b0}, 1'b0);
        step();
        chk("R3", 16'h0000, 1'b0);
        set_lane(0, {16'h0303, 1'b0}, 1'b1);
        step();
        chk("R5", 16'h0303, 1'b1);
    endtask

    task automatic t_interp();
        do_reset();
        cfg_interp = 1'b1;
        release_sync();
        set_lane(0, {16'h7777, 1'b0}, 1'b1);
        step();
        chk("R4", 16'h7777, 1'b1);
        set_lane(0, {16'h6666, 1'b0}, 1'b0);
        step();
        chk("R4", 16'h0000, 1'b1);
        step();
        chk("R4", 16'h0000, 1'b1);
        cfg_interp = 1'b0;
    endtask

    task automatic t_fixed();
        do_reset();
        release_sync();
        set_lane(0, {16'h1234, 1'b0}, 1'b1);
        step();
        chk("R7", 16'h1234, 1'b1);
        cfg_split = 3'd1;
        set_lane(0, 17'h1FFFF, 1'b1);
        step();
        chk("R7", 16'hFFFE, 1'b1);
        cfg_split = 3'd0;
        cfg_offset_bin = 1'b1;
        set_lane(0, {16'h8000, 1'b0}, 1'b1);
        step();
        chk("R6", 16'h0000, 1'b1);
        set_lane(0, 17'h0, 1'b1);
        step();
        chk("R6", 16'h8000, 1'b1);
        cfg_offset_bin = 1'b0;
    endtask

    task automatic t_float();
        do_reset();
        release_sync();
        cfg_float = 1'b1;
        cfg_split = 3'd0;
        set_lane(0, (17'd5 << 6) | 17'd3, 1'b1);
        step();
        chk("R8", 16'd40, 1'b1);
        set_lane(0, (17'h7FD << 6) | 17'd2, 1'b1);
        step();
        chk("R8", 16'hFFF4, 1'b1);
        cfg_split = 3'd1;
        set_lane(0, (17'd7 << 5) | 17'd1, 1'b1);
        step();
        chk("R8", 16'd14, 1'b1);
        cfg_split = 3'd2;
        set_lane(0, (17'h1FF8 << 4), 1'b1);
        step();
        chk("R8", 16'hFFF8, 1'b1);
        cfg_split = 3'd3;
        set_lane(0, (17'd100 << 3) | 17'd3, 1'b1);
        step();
        chk("R8", 16'd800, 1'b1);
        cfg_split = 3'd4;
        set_lane(0, (17'h3FFF << 3) | 17'd7, 1'b1);
        step();
        chk("R8", 16'hFF80, 1'b1);
        cfg_split = 3'd6;
        set_lane(0, (17'd3 << 3) | 17'd2, 1'b1);
        step();
        chk("R8", 16'd12, 1'b1);
        cfg_split = 3'd4;
        set_lane(0, (17'h1000 << 3) | 17'd4, 1'b1);
        step();
        chk("R9", 16'h0000, 1'b1);
        set_lane(0, (17'h0FFF << 3) | 17'd5, 1'b1);
        step();
        chk("R9", 16'hFFE0, 1'b1);
        cfg_split = 3'd0;
        cfg_offset_bin = 1'b1;
        set_lane(0, (17'h401 << 6) | 17'd2, 1'b1);
        step();
        chk("R6", 16'd4, 1'b1);
        set_lane(0, (17'h3FF << 6), 1'b1);
        step();
        chk("R6", 16'hFFFF, 1'b1);
        cfg_offset_bin = 1'b0;
        cfg_float = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        idle();
        cfg_use_test = 1'b0; cfg_src_sel = '0; cfg_interp = 1'b0;
        cfg_offset_bin = 1'b0; cfg_float = 1'b0; cfg_split = '0;
        @(negedge clk);
        t_holdoff();
        t_source();
        t_gated();
        t_interp();
        t_fixed();
        t_float();
        do_reset();
        step();
        chk("R2", 16'h0000, 1'b0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule